// File: doc/BRIEF.md
# Load/Store Uncorrectable-Error Recovery Sequencer

This controller takes over when a load or store finds a raw (not yet marked) uncorrectable error in the data of the first-level cache. It first orders a writeback of the affected line to the second-level cache, whatever the line's clean or dirty state. The doubleword is marked during that writeback. It then orders a refill of the line and checks the refilled data. If the refill brings the raw error back, the writeback and refill pair runs again. Once a fixed number of raw rechecks has been reached, the failing way is disabled for good. After that, the access is serviced from the second-level cache.

When the data holds a marked error, the sequencer replays the access, and the replay raises a precise data-access exception that carries the error-mark identifier captured when the request was accepted. A doubleword store replays without raising the exception. The pipeline is stalled from acceptance until the sequence ends. Requests that arrive during a sequence, and requests naming a way that is already disabled, are dropped.

Top module: `ue_rec_seq`

## Requirements
- R1: After reset, stall_o, wb_req_o, rf_req_o, replay_o and exc_o are 0, and way_dis_o and sticky_raw_o are all zero.
- R2: A request accepted in idle raises wb_req_o in the next cycle, with wb_way_o equal to the request's way. stall_o stays 1 from that cycle until the sequence ends.
- R3: rf_req_o rises only after wb_done_i has completed the writeback. sticky_raw_o becomes 1 once a refill completes and keeps that value until reset.
- R4: If rf_raw_ue_i is 1 when a refill completes and fewer than RETRY_MAX raw rechecks have occurred, another writeback and refill follow. With N raw refills and N < RETRY_MAX, a sequence has exactly N+1 writebacks and N+1 refills.
- R5: On the RETRY_MAX-th raw recheck, the bit of way_dis_o for the request's way (bit index = way number) is set, and no further writeback follows. The sequence has exactly RETRY_MAX writebacks, and l2_bypass_o is 1 during the replay cycle. The bit is never cleared until reset.
- R6: Every sequence ends with a single-cycle replay_o pulse. For a non-doubleword access, this is followed in the next cycle by a single-cycle exc_o pulse, with exc_mark_id_o equal to mark_id_i as sampled at acceptance.
- R7: When req_dw_store_i was 1 at acceptance, the sequence still replays, but exc_o stays 0.
- R8: A request whose way already has its way_dis_o bit set is ignored: no stall and no writeback follow.
- R9: A request that arrives while stall_o is 1 is ignored: the current sequence is unchanged, and no new sequence starts after it.
- R10: wb_req_o and rf_req_o are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Access found a raw uncorrectable error |
| req_way_i | input | WAY_W | Way holding the failing line |
| req_dw_store_i | input | 1 | Access is a doubleword store |
| mark_id_i | input | MARK_W | Error-mark identifier to stamp |
| wb_req_o | output | 1 | Writeback command (level until done) |
| wb_way_o | output | WAY_W | Way to write back / refill |
| wb_done_i | input | 1 | Writeback engine finished |
| rf_req_o | output | 1 | Refill command (level until done) |
| rf_done_i | input | 1 | Refill engine finished |
| rf_raw_ue_i | input | 1 | Refilled data rechecked as raw error (valid with rf_done_i) |
| way_dis_o | output | WAYS | Disabled-way mask |
| l2_bypass_o | output | 1 | Replay is serviced from second-level cache |
| stall_o | output | 1 | Pipeline stall |
| replay_o | output | 1 | Access re-executes this cycle |
| exc_o | output | 1 | Precise data-access exception |
| exc_mark_id_o | output | MARK_W | Mark identifier reported with the exception |
| sticky_raw_o | output | 1 | Sticky raw-error status |

## Verification
If the retry counter is wrong, the number of writeback commands changes within the same sequence. If way reduction is lost or fires early, way_dis_o differs right after that sequence, and a later request to that way either starts or fails to start a stall in the next cycle. Stale request context shows up at the replay: a wrong wb_way_o or exc_mark_id_o, or a missing or extra exc_o, appears in the one or two cycles before stall_o drops. Stimulus mixes random raw-error repeat counts, engine latencies and access kinds with directed limit, doubleword-store, busy and disabled-way cases.

// File: rtl/ue_rec_pkg.sv
package ue_rec_pkg;
  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_WRITEBACK = 3'd1,
    ST_REFILL    = 3'd2,
    ST_RECHECK   = 3'd3,
    ST_WAY_RED   = 3'd4,
    ST_REPLAY    = 3'd5,
    ST_REPORT    = 3'd6
  } rec_state_e;
endpackage

// File: rtl/ue_rec_retry.sv
module ue_rec_retry #(
  parameter int RETRY_MAX = 3,
  localparam int CNT_W = $clog2(RETRY_MAX + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic at_limit_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  // next raw recheck is the one that reduces the way
  assign at_limit_o = (cnt_q == CNT_W'(RETRY_MAX - 1));

  p_cnt_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(RETRY_MAX));
endmodule

// File: rtl/ue_rec_waymask.sv
module ue_rec_waymask #(
  parameter int WAYS = 4,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic [WAY_W-1:0] set_way_i,
  input  logic [WAY_W-1:0] q_way_i,
  output logic             q_dis_o,
  output logic [WAYS-1:0]  mask_o
);
  logic [WAYS-1:0] mask_q;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    mask_q[w] <= 1'b0;
      else if (set_i && (set_way_i == WAY_W'(w)))     mask_q[w] <= 1'b1;
    end
  end

  assign q_dis_o = mask_q[q_way_i];
  assign mask_o  = mask_q;

  p_mask_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mask_q) & ~mask_q) == '0);
  p_one_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(mask_q & ~$past(mask_q)) <= 1);
endmodule

// File: rtl/ue_rec_fsm.sv
module ue_rec_fsm
  import ue_rec_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic accept_i,
  input  logic wb_done_i,
  input  logic rf_done_i,
  input  logic rf_raw_ue_i,
  input  logic at_limit_i,
  input  logic is_dw_i,
  output logic idle_o,
  output logic wb_req_o,
  output logic rf_req_o,
  output logic rf_fin_o,
  output logic cnt_inc_o,
  output logic reduce_o,
  output logic replay_o,
  output logic bypass_o,
  output logic exc_o
);
  rec_state_e state_q, state_d;
  logic raw_q, reduced_q;

  always_comb begin
    state_d   = state_q;
    cnt_inc_o = 1'b0;
    unique case (state_q)
      ST_IDLE:      if (accept_i) state_d = ST_WRITEBACK;
      ST_WRITEBACK: if (wb_done_i) state_d = ST_REFILL;
      ST_REFILL:    if (rf_done_i) state_d = ST_RECHECK;
      ST_RECHECK: begin
        if (!raw_q)          state_d = ST_REPLAY;
        else if (at_limit_i) state_d = ST_WAY_RED;
        else begin
          state_d   = ST_WRITEBACK;
          cnt_inc_o = 1'b1;
        end
      end
      ST_WAY_RED:   state_d = ST_REPLAY;
      ST_REPLAY:    state_d = ST_REPORT;
      ST_REPORT:    state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      raw_q     <= 1'b0;
      reduced_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_REFILL && rf_done_i) raw_q <= rf_raw_ue_i;
      if (accept_i && state_q == ST_IDLE)    reduced_q <= 1'b0;
      else if (state_q == ST_WAY_RED)        reduced_q <= 1'b1;
    end
  end

  assign idle_o   = (state_q == ST_IDLE);
  assign wb_req_o = (state_q == ST_WRITEBACK);
  assign rf_req_o = (state_q == ST_REFILL);
  assign rf_fin_o = (state_q == ST_REFILL) && rf_done_i;
  assign reduce_o = (state_q == ST_WAY_RED);
  assign replay_o = (state_q == ST_REPLAY);
  assign bypass_o = (state_q == ST_REPLAY) && reduced_q;
  assign exc_o    = (state_q == ST_REPORT) && !is_dw_i;

  p_cmd_mutex_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wb_req_o && rf_req_o));
  p_refill_after_wb_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rf_req_o) |-> $past(wb_req_o && wb_done_i));
  p_exc_after_replay_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |-> $past(replay_o));
  p_replay_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    replay_o |=> !replay_o);
  p_no_wb_after_reduce_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reduce_o |=> replay_o);
endmodule

// File: rtl/ue_rec_seq.sv
module ue_rec_seq #(
  parameter int WAYS      = 4,
  parameter int MARK_W    = 8,
  parameter int RETRY_MAX = 3,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [WAY_W-1:0]  req_way_i,
  input  logic              req_dw_store_i,
  input  logic [MARK_W-1:0] mark_id_i,
  output logic              wb_req_o,
  output logic [WAY_W-1:0]  wb_way_o,
  input  logic              wb_done_i,
  output logic              rf_req_o,
  input  logic              rf_done_i,
  input  logic              rf_raw_ue_i,
  output logic [WAYS-1:0]   way_dis_o,
  output logic              l2_bypass_o,
  output logic              stall_o,
  output logic              replay_o,
  output logic              exc_o,
  output logic [MARK_W-1:0] exc_mark_id_o,
  output logic              sticky_raw_o
);
  logic idle, accept, req_dis, at_limit, cnt_inc, reduce, rf_fin;
  logic [WAY_W-1:0]  way_q;
  logic [MARK_W-1:0] mark_q;
  logic              dw_q, sticky_q;

  assign accept = idle && req_valid_i && !req_dis;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      way_q    <= '0;
      mark_q   <= '0;
      dw_q     <= 1'b0;
      sticky_q <= 1'b0;
    end else begin
      if (accept) begin
        way_q  <= req_way_i;
        mark_q <= mark_id_i;
        dw_q   <= req_dw_store_i;
      end
      if (rf_fin) sticky_q <= 1'b1;
    end
  end

  ue_rec_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept),
    .wb_done_i   (wb_done_i),
    .rf_done_i   (rf_done_i),
    .rf_raw_ue_i (rf_raw_ue_i),
    .at_limit_i  (at_limit),
    .is_dw_i     (dw_q),
    .idle_o      (idle),
    .wb_req_o    (wb_req_o),
    .rf_req_o    (rf_req_o),
    .rf_fin_o    (rf_fin),
    .cnt_inc_o   (cnt_inc),
    .reduce_o    (reduce),
    .replay_o    (replay_o),
    .bypass_o    (l2_bypass_o),
    .exc_o       (exc_o)
  );

  ue_rec_retry #(.RETRY_MAX(RETRY_MAX)) u_retry (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (accept),
    .inc_i      (cnt_inc),
    .at_limit_o (at_limit)
  );

  ue_rec_waymask #(.WAYS(WAYS)) u_mask (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (reduce),
    .set_way_i (way_q),
    .q_way_i   (req_way_i),
    .q_dis_o   (req_dis),
    .mask_o    (way_dis_o)
  );

  assign stall_o       = !idle;
  assign wb_way_o      = way_q;
  assign exc_mark_id_o = mark_q;
  assign sticky_raw_o  = sticky_q;

  p_wb_in_stall_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_req_o || rf_req_o || replay_o || exc_o) |-> stall_o);
  p_start_wb_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stall_o) |-> wb_req_o);
  p_sticky_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(sticky_raw_o) |-> sticky_raw_o);
  p_way_stable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && $past(stall_o)) |-> $stable(wb_way_o) && $stable(exc_mark_id_o));
endmodule

// File: tb/ue_rec_seq_tb.sv
module ue_rec_seq_tb;
  localparam int WAYS = 4, MARK_W = 8, RMAX = 3, WAY_W = 2;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic req_valid_i = 0, req_dw_store_i = 0, wb_done_i = 0, rf_done_i = 0, rf_raw_ue_i = 0;
  logic [WAY_W-1:0] req_way_i = '0;
  logic [MARK_W-1:0] mark_id_i = '0;
  logic wb_req_o, rf_req_o, l2_bypass_o, stall_o, replay_o, exc_o, sticky_raw_o;
  logic [WAY_W-1:0] wb_way_o;
  logic [WAYS-1:0] way_dis_o;
  logic [MARK_W-1:0] exc_mark_id_o;

  int nchk = 0, nerr = 0;
  logic [WAYS-1:0] exp_mask = '0;

  always #5 clk_i = ~clk_i;

  ue_rec_seq #(.WAYS(WAYS), .MARK_W(MARK_W), .RETRY_MAX(RMAX)) u_dut (.*);

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic int exp_wb(input int nraw);
    return (nraw >= RMAX) ? RMAX : nraw + 1;
  endfunction

  task automatic run_seq(input int way, input bit dw, input logic [7:0] mark,
                         input int nraw, input bit poke);
    int wbn = 0, rfn = 0, repn = 0, excn = 0, bypn = 0, badway = 0, order = 0;
    logic [7:0] em = '0;
    @(negedge clk_i);
    req_valid_i = 1; req_way_i = WAY_W'(way); req_dw_store_i = dw; mark_id_i = mark;
    @(negedge clk_i);
    req_valid_i = 0; mark_id_i = ~mark; req_dw_store_i = ~dw;
    chk(stall_o && wb_req_o, "R2 start", {stall_o, wb_req_o}, 3);
    forever begin
      if (!stall_o) break;
      if (wb_req_o && rf_req_o) order++;
      if (wb_req_o) begin
        if (wb_way_o != WAY_W'(way)) badway++;
        if (poke && wbn == 0) begin
          req_valid_i = 1; req_way_i = WAY_W'((way + 1) % WAYS);
        end
        repeat ($urandom_range(0, 2)) @(negedge clk_i);
        req_valid_i = 0; req_way_i = WAY_W'(way);
        wb_done_i = 1; wbn++;
        @(negedge clk_i);
        wb_done_i = 0;
        continue;
      end
      if (rf_req_o) begin
        if (rfn >= wbn) order++;
        repeat ($urandom_range(0, 2)) @(negedge clk_i);
        rf_done_i = 1; rf_raw_ue_i = (rfn < nraw); rfn++;
        @(negedge clk_i);
        rf_done_i = 0; rf_raw_ue_i = 0;
        continue;
      end
      if (replay_o) begin repn++; if (l2_bypass_o) bypn++; end
      if (exc_o) begin
        excn++; em = exc_mark_id_o;
        if (repn == 0) order++;
      end
      @(negedge clk_i);
    end
    if (nraw >= RMAX) exp_mask[way] = 1'b1;
    chk(wbn == exp_wb(nraw), (nraw >= RMAX) ? "R5 wb count" : "R4 wb count", wbn, exp_wb(nraw));
    chk(rfn == exp_wb(nraw), "R4 refill count", rfn, exp_wb(nraw));
    chk(badway == 0, "R2 wb_way", badway, 0);
    chk(order == 0, "R3 order", order, 0);
    chk(sticky_raw_o, "R3 sticky", sticky_raw_o, 1);
    chk(repn == 1, "R6 replay", repn, 1);
    chk(bypn == ((nraw >= RMAX) ? 1 : 0), "R5 bypass", bypn, (nraw >= RMAX) ? 1 : 0);
    chk(excn == (dw ? 0 : 1), dw ? "R7 no exc" : "R6 exc", excn, dw ? 0 : 1);
    if (!dw) chk(em == mark, "R6 mark id", em, mark);
    chk(way_dis_o == exp_mask, "R5 mask", way_dis_o, exp_mask);
    @(negedge clk_i);
    chk(!stall_o && !wb_req_o, poke ? "R9 held off" : "R2 idle after", stall_o, 0);
  endtask

  task automatic try_disabled(input int way);
    @(negedge clk_i);
    req_valid_i = 1; req_way_i = WAY_W'(way); mark_id_i = 8'h77;
    @(negedge clk_i);
    req_valid_i = 0;
    chk(!stall_o && !wb_req_o, "R8 disabled way", {stall_o, wb_req_o}, 0);
    repeat (2) @(negedge clk_i);
    chk(!stall_o && way_dis_o == exp_mask, "R8 no effect", way_dis_o, exp_mask);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    nerr++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'h1d2c));
    repeat (3) @(negedge clk_i);
    chk(!stall_o && !wb_req_o && !rf_req_o && !replay_o && !exc_o, "R1 ctl", stall_o, 0);
    chk(way_dis_o == '0 && !sticky_raw_o, "R1 status", way_dis_o, 0);
    rst_ni = 1;
    repeat (2) @(negedge clk_i);
    chk(!stall_o && !sticky_raw_o, "R1 after release", stall_o, 0);

    run_seq(0, 0, 8'h3c, 0, 0);
    run_seq(2, 0, 8'ha5, 1, 0);
    run_seq(3, 0, 8'h11, 2, 0);
    run_seq(1, 0, 8'h5e, 3, 0);
    try_disabled(1);
    run_seq(0, 1, 8'h42, 0, 0);
    run_seq(2, 1, 8'h99, 2, 0);
    run_seq(3, 0, 8'hc3, 1, 1);

    for (int t = 0; t < 24; t++) begin
      int w = $urandom_range(0, WAYS - 1);
      int n = ($urandom_range(0, 9) == 0) ? RMAX + $urandom_range(0, 1) : $urandom_range(0, RMAX - 1);
      if (exp_mask[w]) try_disabled(w);
      else run_seq(w, 1'($urandom_range(0, 1)), 8'($urandom), n, 1'($urandom_range(0, 1)));
    end
    finish_run();
  end
endmodule